// File: doc/BRIEF.md
# Three-Phase Output Shutdown Guard

This block owns the enable path for the six pins that drive a three-phase inverter bridge. The pins are the high-side and low-side outputs of phases U, V and W. While the pins are enabled and the function is on, they carry the raw phase waveforms that an external modulator supplies. The block watches those waveforms for a phase whose two outputs are active together. When that happens it latches a sticky detect flag. If protection is armed, it also drops the output enable on the next clock edge.

A falling edge on an asynchronous active-low fault input also drops the output enable. The fault input is synchronised through two flops before its edge is detected. Software controls the function enable, the output enable and the protection enable through a single write port. It can read all of them back, together with the detect flag. Software can never raise the flag. It can clear the flag only by writing protection off in the same write. When the pins are not carrying the phase waveforms, each pin behaves as a plain port pin: its driver follows the port direction bit, and an input-direction pin is left at high impedance.

Top module: `tph_guard`

## Requirements
- R1: After reset every control bit reads 0 (write and read layout: bit 0 function enable, bit 1 output enable, bit 2 protection enable, bit 3 detect flag), and the pins behave as port pins.
- R2: When the function enable and the protection enable are both 1 and an overlap is seen, the output enable reads 0 and the flag reads 1 after the next clock edge.
- R3: A 1-to-0 transition of fault_ni clears the output enable. If the low level is first sampled at edge k, the output enable reads 0 after edge k+2. Holding fault_ni low or raising it again has no further effect.
- R4: A write takes effect at the next edge, and a write with bit 1 at 0 clears the output enable.
- R5: While the protection enable and the flag are both 1, the output enable reads 0, including after a write that sets it to 1.
- R6: A write with bit 3 at 1 never sets the flag. A write clears the flag only when both bit 3 and bit 2 are 0 in that write. A write with bit 2 at 1 leaves the flag set.
- R7: An overlap occurs when pins 2k and 2k+1 (U/U-bar at 0/1, V/V-bar at 2/3, W/W-bar at 4/5) are both at the active level (high by default) in a sampled cycle. When the function enable is 1, an overlap sets the flag whatever the protection enable is. With protection off, an overlap leaves the output enable unchanged. With the function enable at 0, an overlap does not set the flag.
- R8: While the function enable and the output enable are both 1, every pin driver is on and pin_o equals phase_i in the same cycle.
- R9: Otherwise pin_oe_o equals port_dir_i and pin_o equals port_dat_i. As a result, with the function enabled, the output disabled and the direction at input, all six pins are at high impedance.
- R10: A hardware event takes priority over a write in the same cycle. An overlap sets the flag even when the write would clear it. An overlap seen with protection armed, or a fault edge, clears the output enable even when the write sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 6 | Raw phase waveforms, pair 2k/2k+1 per phase |
| fault_ni | input | 1 | Asynchronous active-low fault input |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 4 | Control write data |
| rd_data_o | output | 4 | Control and flag readback |
| port_dir_i | input | 6 | Port direction per pin, 1 = output |
| port_dat_i | input | 6 | Port data per pin |
| pin_o | output | 6 | Pin output value |
| pin_oe_o | output | 6 | Pin driver enable, 0 = high impedance |

## Verification
Pin values and driver enables follow the inputs within the same cycle. Register readback, the flag and overlap-driven shutdown each appear one edge after the stimulus. A fault edge shows up on the output enable two edges after the low level is first sampled. The bench drives its inputs on the falling clock edge. A behavioural model advances on each rising edge, and the bench compares every output at the next falling edge, so each result is checked in the cycle it is due. Directed checks at the fault edge confirm the enable still reads 1 for the first two cycles and 0 on the third.

// File: rtl/tph_pkg.sv
package tph_pkg;
  typedef struct packed {
    logic flag;
    logic prot_en;
    logic out_en;
    logic func_en;
  } tph_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tph_ctrl_t);
endpackage

// File: rtl/tph_fault_sync.sv
module tph_fault_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_ni,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], fault_ni};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/tph_overlap.sv
module tph_overlap #(
  parameter int unsigned N_PHASE  = 3,
  parameter bit          ACT_HIGH = 1'b1,
  localparam int unsigned PIN_W   = 2 * N_PHASE
) (
  input  logic [PIN_W-1:0] phase_i,
  output logic             hit_o
);
  logic [PIN_W-1:0]   lvl;
  logic [N_PHASE-1:0] pair_hit;

  assign lvl = ACT_HIGH ? phase_i : ~phase_i;

  for (genvar k = 0; k < N_PHASE; k++) begin : g_pair
    assign pair_hit[k] = lvl[2*k] & lvl[2*k+1];
  end

  assign hit_o = |pair_hit;
endmodule

// File: rtl/tph_ctrl.sv
module tph_ctrl
  import tph_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  tph_ctrl_t wr_data_i,
  input  logic      hit_i,
  input  logic      fall_i,
  output tph_ctrl_t ctrl_o
);
  tph_ctrl_t cur_q, nxt;
  logic      trip;

  assign trip = cur_q.func_en & hit_i;

  always_comb begin
    nxt = cur_q;
    if (wr_en_i) begin
      nxt.func_en = wr_data_i.func_en;
      nxt.prot_en = wr_data_i.prot_en;
      nxt.out_en  = wr_data_i.out_en;
      // flag only clears together with protection off
      if (!wr_data_i.flag && !wr_data_i.prot_en) nxt.flag = 1'b0;
    end
    if (trip) nxt.flag = 1'b1;
    if (fall_i || (trip && cur_q.prot_en)) nxt.out_en = 1'b0;
    if (nxt.prot_en && nxt.flag) nxt.out_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= nxt;
  end

  assign ctrl_o = cur_q;
endmodule

// File: rtl/tph_pin_mux.sv
module tph_pin_mux #(
  parameter int unsigned PIN_W = 6
) (
  input  logic             drive_i,
  input  logic [PIN_W-1:0] phase_i,
  input  logic [PIN_W-1:0] port_dir_i,
  input  logic [PIN_W-1:0] port_dat_i,
  output logic [PIN_W-1:0] pin_o,
  output logic [PIN_W-1:0] pin_oe_o
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign pin_oe_o[i] = drive_i | port_dir_i[i];
    assign pin_o[i]    = drive_i ? phase_i[i] : port_dat_i[i];
  end
endmodule

// File: rtl/tph_guard.sv
module tph_guard
  import tph_pkg::*;
#(
  parameter int unsigned N_PHASE     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ACT_HIGH    = 1'b1,
  localparam int unsigned PIN_W      = 2 * N_PHASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_W-1:0]  phase_i,
  input  logic              fault_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic [PIN_W-1:0]  port_dir_i,
  input  logic [PIN_W-1:0]  port_dat_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe_o
);
  logic      fault_fall;
  logic      ovl_hit;
  tph_ctrl_t ctrl_q;

  tph_fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_ni(fault_ni),
    .fall_o  (fault_fall)
  );

  tph_overlap #(.N_PHASE(N_PHASE), .ACT_HIGH(ACT_HIGH)) u_ovl (
    .phase_i(phase_i),
    .hit_o  (ovl_hit)
  );

  tph_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(tph_ctrl_t'(wr_data_i)),
    .hit_i    (ovl_hit),
    .fall_i   (fault_fall),
    .ctrl_o   (ctrl_q)
  );

  tph_pin_mux #(.PIN_W(PIN_W)) u_mux (
    .drive_i   (ctrl_q.func_en & ctrl_q.out_en),
    .phase_i   (phase_i),
    .port_dir_i(port_dir_i),
    .port_dat_i(port_dat_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );

  assign rd_data_o = ctrl_q;
endmodule

// File: rtl/tph_guard_chk.sv
module tph_guard_chk #(
  parameter int unsigned PIN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       rd_data_o,
  input logic [PIN_W-1:0] phase_i,
  input logic [PIN_W-1:0] port_dir_i,
  input logic [PIN_W-1:0] port_dat_i,
  input logic [PIN_W-1:0] pin_o,
  input logic [PIN_W-1:0] pin_oe_o,
  input logic             hit_i,
  input logic             fall_i
);
  logic func, oen, prot, flag;
  assign func = rd_data_o[0];
  assign oen  = rd_data_o[1];
  assign prot = rd_data_o[2];
  assign flag = rd_data_o[3];

  p_trip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func && prot && hit_i) |=> (!oen && flag));

  p_fault_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !oen);

  p_hold_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot && flag) |-> !oen);

  p_no_sw_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && !(func && hit_i)) |=> !flag);

  p_detect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func && hit_i) |=> flag);

  p_pwm_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func && oen) |-> (pin_oe_o == '1 && pin_o == phase_i));

  p_port_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(func && oen) |-> (pin_oe_o == port_dir_i && pin_o == port_dat_i));
endmodule

bind tph_guard tph_guard_chk #(.PIN_W(PIN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_data_o (rd_data_o),
  .phase_i   (phase_i),
  .port_dir_i(port_dir_i),
  .port_dat_i(port_dat_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .hit_i     (ovl_hit),
  .fall_i    (fault_fall)
);

// File: tb/sim_tph_guard.sv
`timescale 1ns/1ps
module sim_tph_guard;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] phase = '0;
  logic          fault_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_data = '0;
  logic [3:0]    rd_data;
  logic [PW-1:0] dir = '0;
  logic [PW-1:0] dat = '0;
  logic [PW-1:0] pin, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tph_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .fault_ni(fault_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .port_dir_i(dir), .port_dat_i(dat), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  // behavioural reference
  bit m_func, m_out, m_prot, m_flag;
  bit fhist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_func = 0; m_out = 0; m_prot = 0; m_flag = 0;
      fhist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit overlap, edge_seen, trip;
      bit n_func, n_out, n_prot, n_flag;
      overlap = 0;
      for (int k = 0; k < PW / 2; k++)
        if (phase[2*k] && phase[2*k+1]) overlap = 1;
      edge_seen = fhist[2] && !fhist[1];
      trip = m_func && overlap;
      n_func = m_func; n_out = m_out; n_prot = m_prot; n_flag = m_flag;
      if (wr_en) begin
        n_func = wr_data[0]; n_out = wr_data[1]; n_prot = wr_data[2];
        if (wr_data[3] == 0 && wr_data[2] == 0) n_flag = 0;
      end
      if (trip) n_flag = 1;
      if (edge_seen) n_out = 0;
      if (trip && m_prot) n_out = 0;
      if (n_prot && n_flag) n_out = 0;
      m_func = n_func; m_out = n_out; m_prot = n_prot; m_flag = n_flag;
      fhist.push_front(fault_n);
      void'(fhist.pop_back());
    end
  end

  task automatic expect_vec(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmp_model(string req);
    logic [3:0]    e_rd;
    logic [PW-1:0] e_oe, e_o;
    bit drv;
    e_rd = {m_flag, m_prot, m_out, m_func};
    drv  = m_func && m_out;
    e_oe = drv ? '1 : dir;
    e_o  = drv ? phase : dat;
    expect_vec(req, "rd_data", {4'h0, rd_data}, {4'h0, e_rd});
    expect_vec(req, "pin_oe", {2'b0, pin_oe}, {2'b0, e_oe});
    expect_vec(req, "pin", {2'b0, pin}, {2'b0, e_o});
  endtask

  task automatic tick(string req);
    @(posedge clk);
    @(negedge clk);
    cmp_model(req);
  endtask

  task automatic wr(string req, logic [3:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(req);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dir = 6'b110011; dat = 6'b101010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tick("R1");
    expect_vec("R1", "rd reset", {4'h0, rd_data}, 8'h00);
    expect_vec("R1", "oe reset", {2'b0, pin_oe}, {2'b0, 6'b110011});

    // R8 waveforms pass through
    wr("R4", 4'b0111);
    expect_vec("R4", "enable", {4'h0, rd_data}, 8'h07);
    phase = 6'b011001; tick("R8");
    expect_vec("R8", "pin", {2'b0, pin}, {2'b0, 6'b011001});
    phase = 6'b100110; tick("R8");
    expect_vec("R8", "oe", {2'b0, pin_oe}, 8'h3f);
    phase = 6'b000000; tick("R8");

    // R2 overlap with protection armed
    phase = 6'b001100; tick("R2");
    expect_vec("R2", "trip", {4'h0, rd_data}, 8'h0d);
    phase = 6'b000000; tick("R2");

    // R5 re-enable blocked
    wr("R5", 4'b0111);
    expect_vec("R5", "held off", {7'h0, rd_data[1]}, 8'h00);

    // R6 flag clear rules
    wr("R6", 4'b0101);
    expect_vec("R6", "flag kept", {7'h0, rd_data[3]}, 8'h01);
    wr("R6", 4'b0011);
    expect_vec("R6", "flag cleared", {4'h0, rd_data}, 8'h03);
    wr("R6", 4'b1001);
    expect_vec("R6", "no sw set", {7'h0, rd_data[3]}, 8'h00);
    wr("R6", 4'b0011);

    // R7 overlap with protection off
    phase = 6'b110000; tick("R7");
    expect_vec("R7", "flag no trip", {4'h0, rd_data}, 8'h0b);
    phase = 6'b000000;
    wr("R7", 4'b0011);
    expect_vec("R7", "cleared", {4'h0, rd_data}, 8'h03);

    // R3 fault edge through synchroniser
    wr("R3", 4'b0111);
    fault_n = 1'b0;
    tick("R3");
    expect_vec("R3", "edge+0", {7'h0, rd_data[1]}, 8'h01);
    tick("R3");
    expect_vec("R3", "edge+1", {7'h0, rd_data[1]}, 8'h01);
    tick("R3");
    expect_vec("R3", "edge+2", {7'h0, rd_data[1]}, 8'h00);
    wr("R3", 4'b0111);
    repeat (4) tick("R3");
    expect_vec("R3", "level no effect", {7'h0, rd_data[1]}, 8'h01);
    fault_n = 1'b1;
    repeat (4) tick("R3");
    expect_vec("R3", "rise no effect", {7'h0, rd_data[1]}, 8'h01);

    // R4 software clear
    wr("R4", 4'b0101);
    expect_vec("R4", "sw off", {4'h0, rd_data}, 8'h05);

    // R9 port / high impedance
    dir = 6'b000000; tick("R9");
    expect_vec("R9", "hiz", {2'b0, pin_oe}, 8'h00);
    dir = 6'b111100; dat = 6'b010101; tick("R9");
    expect_vec("R9", "port drive", {2'b0, pin}, {2'b0, 6'b010101});

    // R7 no detect with function off, R9 port with out_en only
    wr("R7", 4'b0000);
    phase = 6'b000011; tick("R7");
    expect_vec("R7", "func off", {7'h0, rd_data[3]}, 8'h00);
    wr("R9", 4'b0010);
    expect_vec("R9", "func off port", {2'b0, pin_oe}, {2'b0, 6'b111100});
    phase = 6'b000000;

    // R10 hardware beats same-cycle write
    wr("R10", 4'b0111);
    phase = 6'b000011;
    wr("R10", 4'b0011);
    expect_vec("R10", "trip over write", {4'h0, rd_data}, 8'h09);
    wr("R10", 4'b0001);
    expect_vec("R10", "set over clear", {7'h0, rd_data[3]}, 8'h01);
    phase = 6'b000000;
    wr("R10", 4'b0001);
    expect_vec("R10", "clear after", {7'h0, rd_data[3]}, 8'h00);

    repeat (3) tick("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule